// File: doc/BRIEF.md
# AES-128 Round Key Generator

This block turns a 128-bit AES cipher key into the eleven AES-128 round keys and hands them out one at a time through a single stepping interface. A load strobe captures the cipher key and a direction select. In ascending (encryption) order, the first key presented is round key 0. Each next-key strobe then advances one round, up to round key 10. In descending (decryption) order, the first key presented is round key 10. Each next-key strobe then moves one round back toward round key 0.

The block stores nothing beyond the current round key. A forward step derives key i from key i-1. A backward step undoes that derivation: it recovers key i-1 from key i, using the same substitution on a recovered word. A descending load walks the schedule forward internally for ten cycles before it presents round key 10. During that time the valid flag stays low and next-key strobes are ignored. Every S-box is computed from the field inverse and the affine map, so no byte table is written out.

Top module: `rks_top`

## Requirements
- R1: While reset is held and after it is released, with no load yet, `valid_o` is 0, `round_o` is 0 and `rkey_o` is all zeros.
- R2: An ascending load (`load_i`=1, `rev_i`=0) makes `valid_o`=1, `round_o`=0 and `rkey_o` equal to the captured cipher key on the first clock edge after the strobe.
- R3: The forward step builds key i from key i-1. Word t is the last 32-bit column of key i-1, rotated one byte toward byte 0 and passed bytewise through the AES forward S-box. New column 0 is t XOR old column 0 XOR the round constant for i, and each new column j (j=1..3) is new column j-1 XOR old column j. The round constant has high byte 01,02,04,08,10,20,40,80,1B,36 for i=1..10 and zero low bytes. Byte 0 of a column is its most significant byte, and column 0 is the most significant word of the key.
- R4: In ascending order, a next-key strobe while `round_o` is 10 leaves the key and round unchanged, and `valid_o` stays 1.
- R5: A descending load (`load_i`=1, `rev_i`=1) holds `valid_o` at 0 for the ten cycles after the strobe's edge. `valid_o`=1 with `round_o`=10 and round key 10 appears on the 11th edge after the strobe.
- R6: In descending order, a next-key strobe while valid with `round_o`=r>0 presents round key r-1 with `round_o`=r-1 one edge later.
- R7: In descending order, a next-key strobe while `round_o` is 0 leaves the key and round unchanged.
- R8: A next-key strobe while `valid_o` is 0 (after reset or during a descending load) is ignored and does not shorten or alter the pending result.
- R9: A load wins over a simultaneous next-key strobe, and a load during a descending computation abandons it and restarts from the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| key_i | input | 128 | Cipher key, captured on load |
| load_i | input | 1 | Load strobe for cipher key and direction |
| next_i | input | 1 | Request for the next round key in the chosen direction |
| rev_i | input | 1 | Direction captured on load: 0 ascending, 1 descending |
| round_o | output | 4 | Index of the round key on `rkey_o` |
| rkey_o | output | 128 | Current round key |
| valid_o | output | 1 | High when `rkey_o` and `round_o` hold a finished key |

## Verification
An ascending load and every step result are due exactly one edge after the strobe. A descending load is due eleven edges after it, with `valid_o` low on each of the ten edges in between. Each stimulus task records the cycle number at which its result is due, together with the expected round and key from an independent software key expansion. The monitor samples shortly after each rising edge. It checks that `valid_o` stays low on every cycle before a pending descending result. On the due cycle it compares the outputs, and it flags any item that was never taken on time.

// File: rtl/rks_pkg.sv
package rks_pkg;
  localparam int NR     = 10;
  localparam int KEY_W  = 128;
  localparam int WORD_W = 32;
  localparam int NWORD  = KEY_W / WORD_W;
  localparam int NBYTE  = WORD_W / 8;
  localparam int RND_W  = $clog2(NR + 1);

  typedef enum logic [1:0] {ACT_HOLD, ACT_LOAD, ACT_FWD, ACT_BACK} act_e;

  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 8'h00;
    logic [7:0] sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

  // x^254 equals the multiplicative inverse (and maps 0 to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] res = 8'h01;
    logic [7:0] sq  = x;
    for (int i = 1; i < 8; i++) begin
      sq  = gf_mul(sq, sq);
      res = gf_mul(res, sq);
    end
    return res;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox_byte(input logic [7:0] x);
    logic [7:0] v = gf_inv(x);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] rcon_byte(input logic [RND_W-1:0] r);
    logic [7:0] c = 8'h01;
    for (int i = 2; i <= NR; i++)
      if (RND_W'(i) <= r) c = gf_dbl(c);
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] rot_word(input logic [WORD_W-1:0] w);
    return {w[WORD_W-9:0], w[WORD_W-1 -: 8]};
  endfunction
endpackage

// File: rtl/rks_sbox4.sv
module rks_sbox4
  import rks_pkg::*;
(
  input  logic [WORD_W-1:0] w_i,
  output logic [WORD_W-1:0] w_o
);
  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    assign w_o[g*8 +: 8] = sbox_byte(w_i[g*8 +: 8]);
  end
endmodule

// File: rtl/rks_datapath.sv
module rks_datapath
  import rks_pkg::*;
(
  input  logic [KEY_W-1:0] cur_i,
  input  logic [RND_W-1:0] rnd_i,
  output logic [KEY_W-1:0] nxt_o,
  output logic [KEY_W-1:0] prv_o
);
  logic [WORD_W-1:0] v [NWORD];
  logic [WORD_W-1:0] n [NWORD];
  logic [WORD_W-1:0] u [NWORD];
  logic [WORD_W-1:0] fwd_sub, bck_sub;
  logic [7:0]        rc_fwd, rc_bck;

  for (genvar j = 0; j < NWORD; j++) begin : g_split
    assign v[j] = cur_i[KEY_W-1-j*WORD_W -: WORD_W];
    assign nxt_o[KEY_W-1-j*WORD_W -: WORD_W] = n[j];
    assign prv_o[KEY_W-1-j*WORD_W -: WORD_W] = u[j];
  end

  assign rc_fwd = rcon_byte(rnd_i + RND_W'(1));
  assign rc_bck = rcon_byte(rnd_i);

  // forward: key rnd -> key rnd+1
  rks_sbox4 u_sb_fwd (.w_i(rot_word(v[NWORD-1])), .w_o(fwd_sub));

  always_comb begin
    n[0] = v[0] ^ fwd_sub ^ {rc_fwd, {(WORD_W-8){1'b0}}};
    for (int j = 1; j < NWORD; j++) n[j] = n[j-1] ^ v[j];
  end

  // backward: key rnd -> key rnd-1; later words first, word 0 last
  always_comb begin
    for (int j = NWORD-1; j > 0; j--) u[j] = v[j] ^ v[j-1];
    u[0] = v[0] ^ bck_sub ^ {rc_bck, {(WORD_W-8){1'b0}}};
  end

  rks_sbox4 u_sb_bck (.w_i(rot_word(v[NWORD-1] ^ v[NWORD-2])), .w_o(bck_sub));
endmodule

// File: rtl/rks_ctrl.sv
module rks_ctrl
  import rks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             next_i,
  input  logic             rev_i,
  output logic [RND_W-1:0] round_o,
  output logic             valid_o,
  output act_e             act_o
);
  localparam logic [RND_W-1:0] LAST = RND_W'(NR);

  logic [RND_W-1:0] round_q;
  logic             valid_q, busy_q, rev_q;
  logic             step_fwd, step_back, step_held, prep_done;

  assign step_fwd  = !load_i && valid_q && next_i && !rev_q && round_q != LAST;
  assign step_back = !load_i && valid_q && next_i &&  rev_q && round_q != '0;
  assign step_held = !load_i && !valid_q && next_i;
  assign prep_done = busy_q && round_q == LAST - RND_W'(1);

  always_comb begin
    if (load_i)                    act_o = ACT_LOAD;
    else if (busy_q || step_fwd)   act_o = ACT_FWD;
    else if (step_back)            act_o = ACT_BACK;
    else                           act_o = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      round_q <= '0;
      valid_q <= 1'b0;
      busy_q  <= 1'b0;
      rev_q   <= 1'b0;
    end else if (load_i) begin
      round_q <= '0;
      rev_q   <= rev_i;
      busy_q  <= rev_i;
      valid_q <= !rev_i;
    end else if (busy_q) begin
      round_q <= round_q + RND_W'(1);
      if (prep_done) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
      end
    end else if (step_fwd) begin
      round_q <= round_q + RND_W'(1);
    end else if (step_back) begin
      round_q <= round_q - RND_W'(1);
    end
  end

  assign round_o = round_q;
  assign valid_o = valid_q;

  assert_fwd_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && !rev_i |=> valid_o && round_o == '0);
  assert_rev_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && rev_i |=> !valid_o);
  assert_busy_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !valid_o);
  assert_top_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i && valid_o && !rev_q && round_o == LAST && next_i |=> valid_o && round_o == LAST);
  assert_back_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_back |=> valid_o && round_o == $past(round_o) - RND_W'(1));
  assert_floor_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i && valid_o && rev_q && round_o == '0 && next_i |=> round_o == '0);
  assert_held_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_held && !busy_q |=> !valid_o);
endmodule

// File: rtl/rks_top.sv
module rks_top
  import rks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] key_i,
  input  logic             load_i,
  input  logic             next_i,
  input  logic             rev_i,
  output logic [RND_W-1:0] round_o,
  output logic [KEY_W-1:0] rkey_o,
  output logic             valid_o
);
  act_e             act;
  logic [KEY_W-1:0] key_q, key_nxt, key_prv;

  rks_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .next_i(next_i), .rev_i(rev_i),
    .round_o(round_o), .valid_o(valid_o), .act_o(act)
  );

  rks_datapath u_dp (
    .cur_i(key_q), .rnd_i(round_o), .nxt_o(key_nxt), .prv_o(key_prv)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) key_q <= '0;
    else begin
      unique case (act)
        ACT_LOAD: key_q <= key_i;
        ACT_FWD:  key_q <= key_nxt;
        ACT_BACK: key_q <= key_prv;
        default:  key_q <= key_q;
      endcase
    end
  end

  assign rkey_o = key_q;

  assert_load_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && !rev_i |=> rkey_o == $past(key_i));
  assert_hold_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_HOLD |=> rkey_o == $past(rkey_o));
  assert_load_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && next_i |=> round_o == '0);
endmodule

// File: tb/tb_rks_top.sv
module tb_rks_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] key_i = '0;
  logic         load_i = 1'b0, next_i = 1'b0, rev_i = 1'b0;
  logic [3:0]   round_o;
  logic [127:0] rkey_o;
  logic         valid_o;

  rks_top dut (.clk(clk), .rst_n(rst_n), .key_i(key_i), .load_i(load_i),
               .next_i(next_i), .rev_i(rev_i), .round_o(round_o),
               .rkey_o(rkey_o), .valid_o(valid_o));

  always #2 clk = ~clk;

  typedef struct {
    int           due;
    bit           dark;
    bit           want_valid;
    int           rnd;
    logic [127:0] key;
    string        tag;
  } item_t;

  item_t        q[$];
  int           cyc = 0, n_chk = 0, n_bad = 0;
  logic [7:0]   sb [256];
  logic [127:0] ek [11];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] rc_tab(input int i);
    case (i)
      1: return 8'h01; 2: return 8'h02; 3: return 8'h04; 4: return 8'h08;
      5: return 8'h10; 6: return 8'h20; 7: return 8'h40; 8: return 8'h80;
      9: return 8'h1b; default: return 8'h36;
    endcase
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00, s;
      for (int y = 1; y < 256; y++) if (pmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int b = 0; b < 8; b++)
        s[b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8] ^ (((8'h63) >> b) & 1'b1);
      sb[x] = s;
    end
  endtask

  task automatic expand(input logic [127:0] k);
    logic [31:0] w [44];
    for (int i = 0; i < 4; i++) w[i] = k[127 - 32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]};
        t = t ^ {rc_tab(i/4), 24'h0};
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r <= 10; r++) ek[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: pops scoreboard items on their due cycle
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() != 0) begin
        if (cyc < q[0].due && q[0].dark)
          check(!valid_o, q[0].tag, "valid during compute", 128'(valid_o), 128'(0));
        else if (cyc == q[0].due) begin
          if (q[0].want_valid) begin
            check(valid_o, q[0].tag, "valid", 128'(valid_o), 128'(1));
            check(round_o == 4'(q[0].rnd), q[0].tag, "round", 128'(round_o), 128'(q[0].rnd));
            check(rkey_o == q[0].key, q[0].tag, "key", rkey_o, q[0].key);
          end else
            check(!valid_o, q[0].tag, "held-off valid", 128'(valid_o), 128'(0));
          void'(q.pop_front());
        end else if (cyc > q[0].due) begin
          check(1'b0, q[0].tag, "missed due cycle", 128'(cyc), 128'(q[0].due));
          void'(q.pop_front());
        end
      end
    end
  end

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic push(input int lat, input bit dark, input bit want, input int rnd,
                      input logic [127:0] key, input string tag);
    item_t it;
    it.due = cyc + lat; it.dark = dark; it.want_valid = want;
    it.rnd = rnd; it.key = key; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic do_load(input logic [127:0] k, input bit rev, input string tag);
    @(negedge clk);
    expand(k);
    key_i = k; rev_i = rev; load_i = 1'b1;
    if (rev) push(11, 1'b1, 1'b1, 10, ek[10], tag);
    else     push(1, 1'b0, 1'b1, 0, ek[0], tag);
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic do_step(input int rnd, input string tag);
    @(negedge clk);
    next_i = 1'b1;
    push(1, 1'b0, 1'b1, rnd, ek[rnd], tag);
    @(negedge clk);
    next_i = 1'b0;
  endtask

  localparam logic [127:0] KA = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] KB = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] KC = 128'hffeeddccbbaa99887766554433221100;

  initial begin
    build_sbox();
    repeat (3) @(negedge clk);
    check(!valid_o && round_o == 0 && rkey_o == '0, "R1", "reset state",
          {rkey_o[123:0], round_o}, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!valid_o && round_o == 0 && rkey_o == '0, "R1", "after release",
          {rkey_o[123:0], round_o}, 128'h0);

    // R8: next with nothing loaded
    @(negedge clk); next_i = 1'b1; push(1, 1'b0, 1'b0, 0, '0, "R8");
    @(negedge clk); next_i = 1'b0; drain();

    // R2/R3: ascending walk through all rounds
    do_load(KA, 1'b0, "R2"); drain();
    for (int r = 1; r <= 10; r++) begin do_step(r, "R3"); drain(); end
    check(rkey_o == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R3", "known round 10 key",
          rkey_o, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    // R4: step past the last round
    do_step(10, "R4"); drain();
    do_step(10, "R4"); drain();

    // second key, ascending
    do_load(KB, 1'b0, "R2"); drain();
    for (int r = 1; r <= 10; r++) begin do_step(r, "R3"); drain(); end

    // R5/R6/R7: descending
    do_load(KA, 1'b1, "R5"); drain();
    for (int r = 9; r >= 0; r--) begin do_step(r, "R6"); drain(); end
    do_step(0, "R7"); drain();

    // R8: next pulses during descending compute are ignored
    @(negedge clk);
    expand(KC);
    key_i = KC; rev_i = 1'b1; load_i = 1'b1;
    push(11, 1'b1, 1'b1, 10, ek[10], "R8");
    @(negedge clk); load_i = 1'b0;
    @(negedge clk); next_i = 1'b1;
    @(negedge clk);
    @(negedge clk); next_i = 1'b0;
    drain();
    for (int r = 9; r >= 7; r--) begin do_step(r, "R6"); drain(); end

    // R9: load and next together -> load wins
    @(negedge clk);
    expand(KB);
    key_i = KB; rev_i = 1'b0; load_i = 1'b1; next_i = 1'b1;
    push(1, 1'b0, 1'b1, 0, ek[0], "R9");
    @(negedge clk); load_i = 1'b0; next_i = 1'b0;
    drain();

    // R9: load during descending compute restarts it
    @(negedge clk);
    key_i = KA; rev_i = 1'b1; load_i = 1'b1;
    @(negedge clk); load_i = 1'b0;
    repeat (4) @(negedge clk);
    do_load(KC, 1'b1, "R9"); drain();
    do_step(9, "R9"); drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule